// File: doc/BRIEF.md
# Video/CPU Bus Time-Share Controller

This block lets a processor and a display fetch engine share one video memory without a video controller chip. At the start of each frame's visible window it asks the processor for the bus. Once the processor acknowledges, it hands the bus to the display fetch logic for the rest of the visible window. When the window closes it withdraws the request.

The processor therefore runs only during the blank part of every frame, so the two never contend for the memory. With a 2 MHz processor clock and an even split of a roughly 48.8 Hz frame, the processor runs at an effective 1 MHz.

A screen-enable level, normally driven from a software output bit, removes the stall completely so the processor runs at full speed. The enable is sampled only when a visible window opens, so a change never truncates or starts a window part-way through a frame.

Top module: `vidBusShare`

## Requirements
- R1: While `rstN` is low, `busReq` and `dispGrant` are both 0.
- R2: When `visActive` is sampled 1 on a clock edge after being sampled 0 on the previous edge, and `screenEn` is 1 on that edge, `busReq` is 1 after that edge.
- R3: While `busReq` is 1 and `visActive` is 1, an edge that samples `busAck` at 1 makes `dispGrant` 1 after that edge, for as long as `busAck` stays 1.
- R4: `dispGrant` is 1 only while `busReq` and `busAck` are both 1. If `busAck` falls during a grant, `dispGrant` falls in the same cycle and `busReq` stays held.
- R5: An edge that samples `visActive` at 0 makes `busReq` and `dispGrant` 0 after that edge.
- R6: If the window closes before `busAck` is seen, the request is withdrawn after the closing edge and no grant is given in that frame.
- R7: If `screenEn` is 0 on the edge where the window opens, `busReq` stays 0 for the whole frame.
- R8: A change of `screenEn` inside a window has no effect until the next window opens. Turning it off does not cut an active grant short, and turning it on does not start a request.
- R9: `busAck` has no effect while no request is outstanding: `dispGrant` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor-domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| visActive | input | 1 | High during the visible window of a frame; its rising edge marks the frame boundary |
| screenEn | input | 1 | Screen enable, 1 = display on, 0 = display off and no stall |
| busAck | input | 1 | Bus acknowledge from the processor |
| busReq | output | 1 | Bus request to the processor |
| dispGrant | output | 1 | Bus granted to the display fetch logic |

## Verification
A wrong internal state shows as a request that stays up after the window closes, or as a request that never appears in a frame where the screen is on. Both are visible on `busReq` one cycle after the frame edge concerned. A control state that moves to granting without a real acknowledge shows at once as `dispGrant` high while `busAck` or `busReq` is low. A frame-boundary detector that fires at the wrong point shows as a request in a screen-off frame, or one started part-way through a window.

// File: rtl/vidBusSharePkg.sv
package vidBusSharePkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SHOW = 2'd2
  } shareState_t;

  typedef struct packed {
    logic setReq;
    logic clrReq;
    logic setGrant;
    logic clrGrant;
  } shareStrobe_t;

endpackage

// File: rtl/vidBusShareDp.sv
module vidBusShareDp
  import vidBusSharePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         visActive,
  input  logic         busAck,
  input  shareStrobe_t strobe,
  output logic         frameRise,
  output logic         busReq,
  output logic         dispGrant
);

  logic visPrev;
  logic reqQ;
  logic grantQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      visPrev <= 1'b0;
      reqQ    <= 1'b0;
      grantQ  <= 1'b0;
    end else begin
      visPrev <= visActive;
      if (strobe.clrReq)        reqQ <= 1'b0;
      else if (strobe.setReq)   reqQ <= 1'b1;
      if (strobe.clrGrant)      grantQ <= 1'b0;
      else if (strobe.setGrant) grantQ <= 1'b1;
    end
  end

  assign frameRise = visActive & ~visPrev;
  assign busReq    = reqQ;
  // the display owns the bus only while the processor still acknowledges
  assign dispGrant = grantQ & reqQ & busAck;

endmodule

// File: rtl/vidBusShareCtrl.sv
module vidBusShareCtrl
  import vidBusSharePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameRise,
  input  logic         visActive,
  input  logic         screenEn,
  input  logic         busAck,
  output shareStrobe_t strobe
);

  shareState_t state;
  shareState_t stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        // screen enable is only consulted at the frame boundary
        if (frameRise && screenEn) begin
          stateNext     = ST_WAIT;
          strobe.setReq = 1'b1;
        end
      end
      ST_WAIT: begin
        if (!visActive) begin
          // acknowledge never came: abandon this frame's fetch
          stateNext     = ST_IDLE;
          strobe.clrReq = 1'b1;
        end else if (busAck) begin
          stateNext       = ST_SHOW;
          strobe.setGrant = 1'b1;
        end
      end
      ST_SHOW: begin
        if (!visActive) begin
          stateNext       = ST_IDLE;
          strobe.clrReq   = 1'b1;
          strobe.clrGrant = 1'b1;
        end
      end
      default: begin
        stateNext       = ST_IDLE;
        strobe.clrReq   = 1'b1;
        strobe.clrGrant = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/vidBusShare.sv
module vidBusShare
  import vidBusSharePkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic visActive,
  input  logic screenEn,
  input  logic busAck,
  output logic busReq,
  output logic dispGrant
);

  shareStrobe_t strobe;
  logic         frameRise;

  vidBusShareCtrl ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameRise(frameRise),
    .visActive(visActive),
    .screenEn (screenEn),
    .busAck   (busAck),
    .strobe   (strobe)
  );

  vidBusShareDp dp (
    .clk      (clk),
    .rstN     (rstN),
    .visActive(visActive),
    .busAck   (busAck),
    .strobe   (strobe),
    .frameRise(frameRise),
    .busReq   (busReq),
    .dispGrant(dispGrant)
  );

endmodule

// File: rtl/vidBusShareChk.sv
module vidBusShareChk (
  input logic clk,
  input logic rstN,
  input logic visActive,
  input logic screenEn,
  input logic busAck,
  input logic busReq,
  input logic dispGrant
);

  // R1
  always_comb begin
    if (!rstN && $time > 0) begin
      reset_quiet_chk: assert (!busReq) else $error("busReq high in reset");
    end
  end

  // R4
  grant_needs_req_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispGrant |-> (busReq && busAck));

  // R2
  req_on_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(visActive) && screenEn && !busReq) |=> busReq);

  // R5
  release_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    !visActive |=> (!busReq && !dispGrant));

  // R7
  screen_off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(visActive) && !screenEn && !busReq) |=> !busReq);

  // R9
  no_grant_without_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |=> !dispGrant);

  // R3
  grant_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck && visActive) |=> (dispGrant || !busAck || !visActive));

endmodule

bind vidBusShare vidBusShareChk chk (
  .clk      (clk),
  .rstN     (rstN),
  .visActive(visActive),
  .screenEn (screenEn),
  .busAck   (busAck),
  .busReq   (busReq),
  .dispGrant(dispGrant)
);

// File: tb/vidBusShare_test.sv
module vidBusShare_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic visActive = 1'b0;
  logic screenEn = 1'b0;
  logic busAck = 1'b0;
  logic busReq;
  logic dispGrant;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  req;
    logic  gnt;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t cur;

  always #4 clk = ~clk;

  vidBusShare uut (
    .clk      (clk),
    .rstN     (rstN),
    .visActive(visActive),
    .screenEn (screenEn),
    .busAck   (busAck),
    .busReq   (busReq),
    .dispGrant(dispGrant)
  );

  task automatic compare(input logic req, input logic gnt, input string tag);
    checks++;
    if (busReq !== req || dispGrant !== gnt) begin
      fails++;
      $display("FAIL %s: busReq=%b dispGrant=%b expected busReq=%b dispGrant=%b",
               tag, busReq, dispGrant, req, gnt);
    end
  endtask

  // driver: apply inputs at the falling edge, queue the result expected after the next rising edge
  task automatic step(input logic v, input logic s, input logic a,
                      input logic eReq, input logic eGnt, input string tag);
    expItem_t item;
    @(negedge clk);
    visActive = v;
    screenEn  = s;
    busAck    = a;
    item.req  = eReq;
    item.gnt  = eGnt;
    item.tag  = tag;
    expQ.push_back(item);
  endtask

  // monitor: compare shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        cur = expQ.pop_front();
        compare(cur.req, cur.gnt, cur.tag);
      end
    end
  end

  initial begin
    screenEn  = 1'b1;
    busAck    = 1'b1;
    visActive = 1'b1;
    repeat (3) @(negedge clk);
    compare(1'b0, 1'b0, "R1 reset quiet");
    visActive = 1'b0;
    busAck    = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // normal frame with mid-window ack drop and screen-off request
    step(0, 1, 0, 0, 0, "R5 idle before window");
    step(1, 1, 0, 1, 0, "R2 request at window open");
    step(1, 1, 0, 1, 0, "R2 request held awaiting ack");
    step(1, 1, 1, 1, 1, "R3 grant after ack");
    step(1, 0, 1, 1, 1, "R8 screen off mid window keeps grant");
    step(1, 0, 0, 1, 0, "R4 ack drop removes grant, request held");
    step(1, 0, 1, 1, 1, "R3 grant resumes with ack");
    step(0, 0, 1, 0, 0, "R5 release at window end");
    step(0, 0, 1, 0, 0, "R9 ack without request");

    // screen-off frame
    step(1, 0, 0, 0, 0, "R7 no request when screen off at boundary");
    step(1, 1, 0, 0, 0, "R8 screen on mid window does not request");
    step(1, 1, 1, 0, 0, "R9 ack ignored in screen-off frame");
    step(0, 1, 0, 0, 0, "R7 frame ends idle");

    // acknowledge never arrives
    step(1, 1, 0, 1, 0, "R2 request in timeout frame");
    step(1, 1, 0, 1, 0, "R6 still waiting");
    step(0, 1, 0, 0, 0, "R6 request dropped at window end");
    step(0, 1, 1, 0, 0, "R6 late ack gives no grant");

    // ack already high when the window opens
    step(1, 1, 1, 1, 0, "R2 request first, no grant yet");
    step(1, 1, 1, 1, 1, "R3 grant on next edge");
    step(0, 1, 1, 0, 0, "R5 release");

    // one-cycle window
    step(1, 1, 0, 1, 0, "R2 short window request");
    step(0, 1, 0, 0, 0, "R6 short window abandoned");

    while (expQ.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #3;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule